// File: doc/BRIEF.md
# Split-Word 64-bit Timebase Counter

This block keeps a 64-bit count of time since reset and presents it to software through a 32-bit APB-style register port. The bus cannot move 64 bits in one access, so the block keeps multi-word accesses coherent. A read of the low half also captures the high half into a holding register, and a later read of the high half returns that captured value. A write of the low half is held in a staging register and reaches the counter only when the high half is written, so the counter takes the whole 64-bit value in one step.

The counter advances by one for each enabled count event. The count event is either a pulse on an external tick strobe or every system clock cycle, chosen by a source-select bit. Counting stops while a software pause bit is set. It also stops while either of two debug-halt inputs is active, if the enable bit for that input is set. A sticky lock bit, once set, blocks every later register write until reset. Two raw read addresses return the live counter halves and leave the holding register alone.

Top module: `tbase_split64`

## Requirements
- R1: After reset the counter is 0, the pause bit (0x30 bit 0) is 0, the source bit (0x38 bit 0) is 0, the lock bit (0x34 bit 0) is 0, and register 0x2C reads 0x6: both debug-halt enables are set.
- R2: A write to 0x04 only stages the low half and leaves the counter unchanged. A write to 0x00 loads the counter with {written data, staged low half}. In that cycle the load takes priority over an increment.
- R3: A read of 0x0C returns the live low half and captures the live high half. A read of 0x08 returns the captured high half, even if the counter has moved on since the capture.
- R4: Reads of 0x24 (live high half) and 0x28 (live low half) return the live counter and do not change the captured high half.
- R5: With 0x38 bit 0 = 0 the counter advances once for each clock cycle in which `tick_i` is high. With 0x38 bit 0 = 1 it advances on every clock cycle. A carry out of the low half propagates into the high half.
- R6: While 0x30 bit 0 is 1 the counter holds its value, in both source modes.
- R7: 0x2C bit 1 enables halting while `dbg_halt_i[0]` is high, and 0x2C bit 2 enables halting while `dbg_halt_i[1]` is high. A halt input whose enable bit is 0 has no effect.
- R8: Writing 1 to 0x34 bit 0 sets the lock. Writing 0 there does not set it. Once the lock is set, every register write is ignored, including writes that would clear the lock, until reset. Counting continues.
- R9: `pready` is always 1 and `pslverr` is always 0. The write-only addresses 0x00 and 0x04 and all unmapped addresses read as 0.
- R10: The pause, source, lock and debug-enable registers read back the values last written to them, with unused bits reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data |
| pready | output | 1 | APB ready, always 1 |
| pslverr | output | 1 | APB error, always 0 |
| tick_i | input | 1 | External count strobe, one count per high cycle |
| dbg_halt_i | input | 2 | Debug-halt requests from two sources |

## Verification
The bench goes after the carry from the low half into the high half while a captured high value is outstanding. A design that read the high half live, or that let raw reads reload the holding register, would return the new high value instead of the captured one. It checks that a staged low half stays invisible until the high write, and that a load which lands during continuous counting restarts from the loaded value. If the increment won over the load, the count would be off by one. It sweeps all sixteen combinations of debug-halt enables and halt inputs, and checks tick counts from zero to six pulses. It also tries to clear the lock and to write the time after locking; a lock that was not sticky, or that covered only some registers, would let those writes change the readback.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
  // Register offsets; software decodes these, so they are fixed.
  localparam logic [7:0] OFF_WR_HI   = 8'h00;
  localparam logic [7:0] OFF_WR_LO   = 8'h04;
  localparam logic [7:0] OFF_RD_HI   = 8'h08;
  localparam logic [7:0] OFF_RD_LO   = 8'h0C;
  localparam logic [7:0] OFF_RAW_HI  = 8'h24;
  localparam logic [7:0] OFF_RAW_LO  = 8'h28;
  localparam logic [7:0] OFF_DBG_EN  = 8'h2C;
  localparam logic [7:0] OFF_PAUSE   = 8'h30;
  localparam logic [7:0] OFF_LOCK    = 8'h34;
  localparam logic [7:0] OFF_SRC     = 8'h38;

  localparam int NUM_DBG = 2;

  typedef enum logic {
    SRC_TICK = 1'b0,
    SRC_CLK  = 1'b1
  } cnt_src_e;
endpackage

// File: rtl/tbase_rst_sync.sv
module tbase_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/tbase_counter.sv
module tbase_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = ld_i | inc_i;
    cnt_d  = cnt_q;
    if (ld_i)       cnt_d = ld_val_i;          // load wins over increment
    else if (inc_i) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  assert_load_wins_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    ld_i |=> (cnt_q == $past(ld_val_i)));

  assert_step_one_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (inc_i && !ld_i) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (!inc_i && !ld_i) |=> $stable(cnt_q));
endmodule

// File: rtl/tbase_regs.sv
module tbase_regs
  import tbase_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [ADDR_W-1:0]  paddr,
  input  logic [DATA_W-1:0]  pwdata,
  input  logic               tick_i,
  input  logic [NUM_DBG-1:0] dbg_halt_i,
  input  logic [CNT_W-1:0]   cnt_i,
  output logic [DATA_W-1:0]  prdata,
  output logic               ld_o,
  output logic [CNT_W-1:0]   ld_val_o,
  output logic               inc_o
);
  logic               wr_acc, rd_acc;
  logic [DATA_W-1:0]  stage_q;
  logic [DATA_W-1:0]  hi_lat_q;
  logic [NUM_DBG-1:0] dbg_en_q, dbg_en_d;
  logic               pause_q, pause_d;
  logic               lock_q, lock_d;
  cnt_src_e           src_q, src_d;
  logic               stage_en, lat_en, dbg_en_we, pause_we, lock_we, src_we;
  logic               evt, halt;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] off);
    return a == ADDR_W'(off);
  endfunction

  // Decode
  always_comb begin
    wr_acc    = psel & penable & pwrite & ~lock_q;
    rd_acc    = psel & penable & ~pwrite;
    stage_en  = wr_acc & hit(paddr, OFF_WR_LO);
    ld_o      = wr_acc & hit(paddr, OFF_WR_HI);
    lat_en    = rd_acc & hit(paddr, OFF_RD_LO);
    dbg_en_we = wr_acc & hit(paddr, OFF_DBG_EN);
    pause_we  = wr_acc & hit(paddr, OFF_PAUSE);
    lock_we   = wr_acc & hit(paddr, OFF_LOCK) & pwdata[0];
    src_we    = wr_acc & hit(paddr, OFF_SRC);
    ld_val_o  = {pwdata, stage_q};
    dbg_en_d  = pwdata[NUM_DBG:1];
    pause_d   = pwdata[0];
    lock_d    = 1'b1;
    src_d     = cnt_src_e'(pwdata[0]);
  end

  // Count event gating
  always_comb begin
    evt   = (src_q == SRC_CLK) ? 1'b1 : tick_i;
    halt  = pause_q | (|(dbg_en_q & dbg_halt_i));
    inc_o = evt & ~halt;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q  <= '0;
      hi_lat_q <= '0;
      dbg_en_q <= '1;
      pause_q  <= 1'b0;
      lock_q   <= 1'b0;
      src_q    <= SRC_TICK;
    end else begin
      if (stage_en)  stage_q  <= pwdata;
      if (lat_en)    hi_lat_q <= cnt_i[CNT_W-1:DATA_W];
      if (dbg_en_we) dbg_en_q <= dbg_en_d;
      if (pause_we)  pause_q  <= pause_d;
      if (lock_we)   lock_q   <= lock_d;
      if (src_we)    src_q    <= src_d;
    end
  end

  // Read mux
  always_comb begin
    prdata = '0;
    if (hit(paddr, OFF_RD_HI))       prdata = hi_lat_q;
    else if (hit(paddr, OFF_RD_LO))  prdata = cnt_i[DATA_W-1:0];
    else if (hit(paddr, OFF_RAW_HI)) prdata = cnt_i[CNT_W-1:DATA_W];
    else if (hit(paddr, OFF_RAW_LO)) prdata = cnt_i[DATA_W-1:0];
    else if (hit(paddr, OFF_DBG_EN)) prdata[NUM_DBG:1] = dbg_en_q;
    else if (hit(paddr, OFF_PAUSE))  prdata[0] = pause_q;
    else if (hit(paddr, OFF_LOCK))   prdata[0] = lock_q;
    else if (hit(paddr, OFF_SRC))    prdata[0] = src_q;
  end

  assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    lock_q |=> lock_q);

  assert_locked_no_load_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    lock_q |-> !ld_o);

  assert_latch_only_on_low_read_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    !(rd_acc && hit(paddr, OFF_RD_LO)) |=> $stable(hi_lat_q));

  assert_pause_blocks_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    pause_q |-> !inc_o);
endmodule

// File: rtl/tbase_split64.sv
module tbase_split64
  import tbase_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [ADDR_W-1:0]  paddr,
  input  logic [DATA_W-1:0]  pwdata,
  output logic [DATA_W-1:0]  prdata,
  output logic               pready,
  output logic               pslverr,
  input  logic               tick_i,
  input  logic [NUM_DBG-1:0] dbg_halt_i
);
  localparam int CNT_W = 2 * DATA_W;

  logic             rst_sync_n;
  logic             ld;
  logic [CNT_W-1:0] ld_val;
  logic             inc;
  logic [CNT_W-1:0] cnt;

  tbase_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_ni      (rst_n),
    .rst_sync_no (rst_sync_n)
  );

  tbase_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_ni     (rst_sync_n),
    .psel       (psel),
    .penable    (penable),
    .pwrite     (pwrite),
    .paddr      (paddr),
    .pwdata     (pwdata),
    .tick_i     (tick_i),
    .dbg_halt_i (dbg_halt_i),
    .cnt_i      (cnt),
    .prdata     (prdata),
    .ld_o       (ld),
    .ld_val_o   (ld_val),
    .inc_o      (inc)
  );

  tbase_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_ni   (rst_sync_n),
    .ld_i     (ld),
    .ld_val_i (ld_val),
    .inc_i    (inc),
    .cnt_o    (cnt)
  );

  assign pready  = 1'b1;
  assign pslverr = 1'b0;
endmodule

// File: tb/sim_tbase_split64.sv
module sim_tbase_split64;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        psel, penable, pwrite;
  logic [7:0]  paddr;
  logic [31:0] pwdata;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic        tick_i;
  logic [1:0]  dbg_halt_i;

  int n_tests = 0;
  int n_fail  = 0;
  longint cyc = 0;
  longint last_ld_edge = 0;
  longint rd_cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tbase_split64 u0 (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .tick_i(tick_i), .dbg_halt_i(dbg_halt_i)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    last_ld_edge = cyc + 1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    #1;
    d = prdata;
    rd_cyc = cyc;
    chk("R9 pready/pslverr", {pready, pslverr}, 2'b10);
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic ticks(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
    end
  endtask

  // Two raw-low samples; returns difference and cycles between them.
  task automatic span(output longint diff, output longint cycles);
    logic [31:0] a, b;
    longint ca;
    rd(8'h28, a); ca = rd_cyc;
    rd(8'h28, b);
    diff = longint'(b - a);
    cycles = rd_cyc - ca;
  endtask

  initial begin
    logic [31:0] v, v2;
    longint diff, cycles;
    psel = 0; penable = 0; pwrite = 0; paddr = 0; pwdata = 0;
    tick_i = 0; dbg_halt_i = 0; rst_n = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset values
    rd(8'h28, v); chk("R1 low", v, 0);
    rd(8'h24, v); chk("R1 high", v, 0);
    rd(8'h2C, v); chk("R1 dbg enables", v, 32'h6);
    rd(8'h30, v); chk("R1 pause", v, 0);
    rd(8'h34, v); chk("R1 lock", v, 0);
    rd(8'h38, v); chk("R1 source", v, 0);

    // R2 staging
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h28, v); chk("R2 staged low invisible", v, 0);
    wr(8'h00, 32'h7);
    rd(8'h28, v); chk("R2 low after commit", v, 32'hFFFF_FFFF);
    rd(8'h24, v); chk("R2 high after commit", v, 32'h7);

    // R3/R4 capture across carry
    rd(8'h0C, v); chk("R3 live low", v, 32'hFFFF_FFFF);
    ticks(1);
    rd(8'h24, v); chk("R5 carry into high", v, 32'h8);
    rd(8'h28, v); chk("R5 low wrapped", v, 0);
    rd(8'h08, v); chk("R4 raw reads keep capture / R3", v, 32'h7);
    rd(8'h0C, v); chk("R3 live low 2", v, 0);
    rd(8'h08, v); chk("R3 recapture", v, 32'h8);

    // R5 tick source sweep
    for (int k = 0; k <= 6; k++) begin
      rd(8'h28, v);
      ticks(k);
      rd(8'h28, v2);
      chk("R5 tick count", longint'(v2 - v), k);
    end

    // R5 clock source
    wr(8'h38, 32'h1);
    rd(8'h38, v); chk("R10 source readback", v, 1);
    for (int k = 0; k < 3; k++) begin
      span(diff, cycles);
      chk("R5 clock count", diff, cycles);
    end

    // R2 load wins over increment
    wr(8'h04, 32'h100);
    wr(8'h00, 32'h0);
    rd(8'h28, v);
    chk("R2 load priority", v, 32'h100 + (rd_cyc - last_ld_edge));

    // R6 pause
    wr(8'h30, 32'h1);
    rd(8'h30, v); chk("R10 pause readback", v, 1);
    span(diff, cycles); chk("R6 paused clock src", diff, 0);
    wr(8'h38, 32'h0);
    rd(8'h28, v); ticks(3); rd(8'h28, v2);
    chk("R6 paused tick src", longint'(v2 - v), 0);
    wr(8'h30, 32'h0);
    wr(8'h38, 32'h1);

    // R7 debug halt sweep
    for (int en = 0; en < 4; en++) begin
      wr(8'h2C, 32'(en << 1));
      rd(8'h2C, v); chk("R10 dbg readback", v, en << 1);
      for (int h = 0; h < 4; h++) begin
        @(negedge clk); dbg_halt_i = 2'(h);
        span(diff, cycles);
        chk("R7 debug halt", diff, ((en & h) != 0) ? 0 : cycles);
      end
    end
    @(negedge clk); dbg_halt_i = 0;
    wr(8'h2C, 32'h6);
    wr(8'h38, 32'h0);

    // R9 reads of write-only / unmapped
    rd(8'h00, v); chk("R9 write-only high", v, 0);
    rd(8'h04, v); chk("R9 write-only low", v, 0);
    rd(8'h3C, v); chk("R9 unmapped 3C", v, 0);
    rd(8'hFC, v); chk("R9 unmapped FC", v, 0);

    // R8 lock
    wr(8'h34, 32'h0);
    rd(8'h34, v); chk("R8 zero does not lock", v, 0);
    wr(8'h34, 32'h1);
    rd(8'h34, v); chk("R8 lock set", v, 1);
    rd(8'h28, v);
    wr(8'h04, 32'h5);
    wr(8'h00, 32'h5);
    rd(8'h28, v2); chk("R8 time write blocked low", v2, v);
    rd(8'h24, v2); chk("R8 time write blocked high", v2, 0);
    wr(8'h30, 32'h1);
    rd(8'h30, v2); chk("R8 pause write blocked", v2, 0);
    wr(8'h38, 32'h1);
    rd(8'h38, v2); chk("R8 source write blocked", v2, 0);
    wr(8'h2C, 32'h0);
    rd(8'h2C, v2); chk("R8 dbg write blocked", v2, 32'h6);
    wr(8'h34, 32'h0);
    rd(8'h34, v2); chk("R8 lock not clearable", v2, 1);
    rd(8'h28, v); ticks(2); rd(8'h28, v2);
    chk("R8 counting continues", longint'(v2 - v), 2);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #2_000_000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule